// File: doc/BRIEF.md
# SPI-Loaded Chip-Select Expander

This block lets one SPI master reach up to eight peripherals while using only two of its own select lines. One select line is for configuration. While it is held low, the shared serial clock and data-out lines shift a small index into the block. The other select line is the routed select. The block passes it to exactly one of its active-low select outputs, the one that the stored index chooses. Every other output stays high.

All serial pins are sampled with the block's own system clock. Each pin goes through a two-stage synchroniser, and the block finds the clock and select edges from the sampled values. The serial clock must run slower than a quarter of the system clock. An index update takes effect only when the configuration select returns high after exactly the index width of clock pulses. The index cannot change while the routed select is active, so a peripheral is never switched in the middle of a transfer.

Top module: `cs_expander`

## Requirements
- R1: After reset every select output is high and the stored index is 0. An active routed select then drives output 0 low.
- R2: While the routed select is low, exactly one output is low: the output whose number equals the stored index. All other outputs are high.
- R3: While the configuration select is low, each rising serial-clock edge shifts the data-in bit into the index, most significant bit first (mode 0). The shifted value becomes the stored index after the configuration select goes high.
- R4: While the routed select is high, all outputs are high, and they return high within a few system clocks after the routed select rises.
- R5: Serial-clock edges that occur while the configuration select is high do not change the stored index.
- R6: If the configuration select rises after a number of rising serial-clock edges other than the index width (3), the update is dropped and the previous index stays in use. This holds for both fewer and more pulses.
- R7: An update that completes while the routed select is low does not change the routed output. It takes effect once the routed select has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, more than four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| cfg_sel_n | input | 1 | Active-low select that frames an index load |
| route_sel_n | input | 1 | Active-low select to be passed to one output |
| sel_out_n | output | 8 | Active-low expanded select outputs |

## Verification
The bench loads the indices 6, 1 and 3. Their bit patterns are not palindromes, so a design that shifts least significant bit first would pick a different output, and the bench can tell the two orders apart. It also sweeps all eight indices, which shows that each output can be reached and that no other output goes low with it. Loads framed with two and with four clock pulses test that a wrong length is dropped. The four-pulse pattern is chosen so that its last three bits would select a different output if the design accepted it. Clock toggling with the configuration select high, and a load that finishes during an active routed select, show that the outputs keep the old routing until the required moment.

// File: rtl/csx_pkg.sv
package csx_pkg;
  // Bit positions of the pins inside the synchroniser bundle
  typedef enum int unsigned {
    PIN_SCLK  = 0,
    PIN_MOSI  = 1,
    PIN_CFG   = 2,
    PIN_ROUTE = 3
  } csx_pin_e;

  localparam int unsigned PIN_COUNT = 4;
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1100; // selects idle high, sclk/mosi low
endpackage

// File: rtl/csx_sync.sv
module csx_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,            // two or more
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_nx;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/csx_index.sv
module csx_index #(
  parameter int unsigned IDX_W = 3               // two or more
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             mosi_s,
  input  logic             cfg_n_s,
  input  logic             route_n_s,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned CNT_W = $clog2(IDX_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IDX_W);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(IDX_W + 1);

  logic             sclk_d, cfg_d;
  logic [IDX_W-1:0] shreg_q, shreg_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             pend_vld_q, pend_vld_nx;
  logic [IDX_W-1:0] pend_idx_q, pend_idx_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic             sclk_rise, cfg_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cfg_rise  = cfg_n_s & ~cfg_d;

  always_comb begin
    shreg_nx    = shreg_q;
    cnt_nx      = cnt_q;
    pend_vld_nx = pend_vld_q;
    pend_idx_nx = pend_idx_q;
    idx_nx      = idx_q;
    if (!cfg_n_s) begin
      if (sclk_rise) begin
        shreg_nx = {shreg_q[IDX_W-2:0], mosi_s};
        if (cnt_q != CNT_CAP) cnt_nx = cnt_q + 1'b1;
      end
    end else begin
      cnt_nx = '0;
    end
    // commit a waiting update only while the routed select is idle
    if (pend_vld_q && route_n_s) begin
      idx_nx      = pend_idx_q;
      pend_vld_nx = 1'b0;
    end
    // a correctly framed load replaces whatever is waiting
    if (cfg_rise && (cnt_q == CNT_FULL)) begin
      pend_vld_nx = 1'b1;
      pend_idx_nx = shreg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      cfg_d      <= 1'b1;
      shreg_q    <= '0;
      cnt_q      <= '0;
      pend_vld_q <= 1'b0;
      pend_idx_q <= '0;
      idx_q      <= '0;
    end else begin
      sclk_d     <= sclk_s;
      cfg_d      <= cfg_n_s;
      shreg_q    <= shreg_nx;
      cnt_q      <= cnt_nx;
      pend_vld_q <= pend_vld_nx;
      pend_idx_q <= pend_idx_nx;
      idx_q      <= idx_nx;
    end
  end

  assign idx_o = idx_q;

  AST_CFG_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_n_s && cfg_d) |=> $stable(shreg_q)); // R5
  AST_BAD_LEN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rise && (cnt_q != CNT_FULL)) |=> $stable(pend_idx_q)); // R6
  AST_IDX_FROZEN_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_n_s) |=> $stable(idx_q)); // R7
  AST_IDX_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> $past(pend_vld_q)); // R3
endmodule

// File: rtl/csx_route.sv
module csx_route #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned N_OUT = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             route_n_s,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_OUT-1:0] sel_n_o
);
  logic [N_OUT-1:0] sel_n_q, sel_n_nx;

  for (genvar g = 0; g < N_OUT; g++) begin : g_dec
    always_comb sel_n_nx[g] = route_n_s | (idx_i != IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_n_q <= '1;
    else        sel_n_q <= sel_n_nx;
  end

  assign sel_n_o = sel_n_q;

  AST_AT_MOST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n_q) <= 1); // R2
  AST_ROUTE_HITS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_n_s) |=> !sel_n_q[$past(idx_i)]); // R2
  AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    route_n_s |=> (&sel_n_q)); // R4
endmodule

// File: rtl/cs_expander.sv
module cs_expander
  import csx_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_OUT = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  input  logic             cfg_sel_n,
  input  logic             route_sel_n,
  output logic [N_OUT-1:0] sel_out_n
);
  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic [IDX_W-1:0]     idx;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_SCLK]  = spi_sclk;
    pins_raw[PIN_MOSI]  = spi_mosi;
    pins_raw[PIN_CFG]   = cfg_sel_n;
    pins_raw[PIN_ROUTE] = route_sel_n;
  end

  csx_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s)
  );

  csx_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[PIN_SCLK]), .mosi_s(pins_s[PIN_MOSI]),
    .cfg_n_s(pins_s[PIN_CFG]), .route_n_s(pins_s[PIN_ROUTE]),
    .idx_o(idx)
  );

  csx_route #(.IDX_W(IDX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .route_n_s(pins_s[PIN_ROUTE]),
    .idx_i(idx), .sel_n_o(sel_out_n)
  );
endmodule

// File: tb/sim_cs_expander.sv
`timescale 1ns/1ps
module sim_cs_expander;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk, mosi, cfg_n, route_n;
  logic [7:0] sel_n;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cs_expander u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .cfg_sel_n(cfg_n), .route_sel_n(route_n), .sel_out_n(sel_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (sel_n !== exp) begin
      n_fail++;
      $display("FAIL %s: sel_out_n=%b expected=%b", req, sel_n, exp);
    end
  endtask

  function automatic logic [7:0] pick(input int i);
    return ~(8'b1 << i);
  endfunction

  // frame nbits of val (MSB first) with the configuration select
  task automatic spi_load(input logic [7:0] val, input int nbits);
    cfg_n = 1'b0; tick(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      mosi = val[b]; tick(4);
      sclk = 1'b1;   tick(4);
      sclk = 1'b0;
    end
    tick(4); cfg_n = 1'b1; tick(10);
  endtask

  task automatic route_check(input string req, input logic [7:0] exp);
    route_n = 1'b0; tick(8);
    chk(req, exp);
    route_n = 1'b1; tick(8);
    chk("R4", 8'hFF);
  endtask

  task automatic t_reset;
    chk("R1", 8'hFF);
    route_check("R1", pick(0));
  endtask

  task automatic t_load_order;
    spi_load(8'd6, 3); route_check("R3", pick(6));
    spi_load(8'd1, 3); route_check("R3", pick(1));
    spi_load(8'd3, 3); route_check("R3", pick(3));
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 8; i++) begin
      spi_load(8'(i), 3);
      route_n = 1'b0; tick(8);
      chk("R2", pick(i));
      route_n = 1'b1; tick(8);
    end
  endtask

  task automatic t_idle_clock;
    spi_load(8'd2, 3);
    for (int k = 0; k < 5; k++) begin
      mosi = k[0]; tick(4);
      sclk = 1'b1; tick(4);
      sclk = 1'b0;
    end
    tick(10);
    route_check("R5", pick(2));
  endtask

  task automatic t_bad_length;
    spi_load(8'd5, 3);
    spi_load(8'b11, 2);      // too short
    route_check("R6", pick(5));
    spi_load(8'b0110, 4);    // too long; last three bits would give 6
    route_check("R6", pick(5));
  endtask

  task automatic t_hold_while_routed;
    spi_load(8'd1, 3);
    route_n = 1'b0; tick(8);
    spi_load(8'd4, 3);
    tick(6);
    chk("R7", pick(1));
    route_n = 1'b1; tick(8);
    route_check("R7", pick(4));
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; mosi = 1'b0; cfg_n = 1'b1; route_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_load_order;
    t_sweep;
    t_idle_clock;
    t_bad_length;
    t_hold_while_routed;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule